// File: doc/BRIEF.md
# Boot ROM Window Decoder

This block watches host memory cycles on a 20-bit address bus and decides whether each one targets an external boot ROM. The ROM occupies a window in host memory. Two values set the window: a base address and a size mask, each held in its own register of a small register window. The mask works in 4 KB pages, so its lowest 12 bits carry no meaning and are treated as zero. A mask whose page bits are all zero switches the window off.

When a memory read falls inside the window, the block pulls an active-low chip select to the ROM and its data transceiver. The ROM then supplies the byte and the transceiver puts it on the host data bus. Memory writes, I/O cycles and cycles with more than one strobe active never assert the select. Software programs the window by writing the two registers. For example, a base of D0000h and a mask of FC000h map a 16 KB ROM from D0000h to D3FFFh.

Top module: `bootwin_decoder`

## Requirements
- R1: After reset, base and mask are both zero, so the window is off and `rom_cs_n` is high even during memory reads.
- R2: A write with `reg_wr` high loads the base from `reg_wdata` when `reg_addr` is 30h, and loads the mask when `reg_addr` is 34h. A write to any other offset changes nothing. A new value takes effect for bus cycles sampled at the clock edge after the write edge.
- R3: A memory read hits when, for every page bit i in [19:12] whose mask bit is 1, address bit i equals base bit i. Address bits [11:0] and base bits [11:0] have no effect.
- R4: `rom_cs_n` goes low only when the sampled strobes are exactly `mem_rd_n`=0, `mem_wr_n`=1, `io_rd_n`=1 and `io_wr_n`=1, and the address hits. Any other strobe combination keeps it high.
- R5: `rom_cs_n` is a register. It shows the strobes and address sampled at the previous rising clock edge. It stays low for as long as a hitting read is held, and it returns high on the first edge after `mem_rd_n` is released.
- R6: When mask bits [19:12] are all zero, no address selects the ROM. This holds even if the low 12 mask bits are set.
- R7: With base D0000h and mask FC000h, reads from D0000h through D3FFFh select the ROM. Reads at CFFFFh and at D4000h do not.
- R8: Mask bits [11:0] are ignored. A mask of FCFFFh selects exactly the same addresses as FC000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register window offset |
| reg_wdata | input | 20 | Register write data |
| host_addr | input | 20 | Host memory address |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| rom_cs_n | output | 1 | Boot ROM and transceiver select, active low |

## Verification
The bench builds two copies of the block. The first uses the default 20-bit address with 4 KB pages. It covers the reset state, the D0000h/FC000h example with its edge addresses, the strobe qualification, the hold and release timing, and ignored mask bits. The second uses a 14-bit address with 256-byte pages, which leaves six page bits. That makes it feasible to apply every one of the 64 masks, two bases per mask and every page under each setting. Each setting mixes in all sixteen strobe combinations and writes to unused offsets, and every result is compared with the match rule computed in the bench.

// File: rtl/bootwin_pkg.sv
package bootwin_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_MEM_RD = 2'd1,
        BUS_OTHER  = 2'd2
    } bus_kind_e;

    // Classify the sampled strobes; only a lone memory read counts as a read.
    function automatic bus_kind_e classify(input logic mem_rd_n, input logic mem_wr_n,
                                           input logic io_rd_n,  input logic io_wr_n);
        logic [3:0] act;
        act = ~{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
        if (act == 4'b0000)      return BUS_IDLE;
        else if (act == 4'b1000) return BUS_MEM_RD;
        else                     return BUS_OTHER;
    endfunction

endpackage

// File: rtl/bootwin_regs.sv
module bootwin_regs #(
    parameter int ADDR_W = 20,
    parameter int GRAN_W = 12,
    parameter int REG_AW = 8,
    parameter logic [REG_AW-1:0] BASE_OFS = 8'h30,
    parameter logic [REG_AW-1:0] MASK_OFS = 8'h34
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          wr_addr,
    input  logic [ADDR_W-GRAN_W-1:0]   wr_page,
    output logic [ADDR_W-GRAN_W-1:0]   base_page,
    output logic [ADDR_W-GRAN_W-1:0]   mask_page
);
    localparam int PAGE_W = ADDR_W - GRAN_W;

    typedef struct packed {
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == BASE_OFS) regs_d.base = wr_page;
            if (wr_addr == MASK_OFS) regs_d.mask = wr_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign base_page = regs_q.base;
    assign mask_page = regs_q.mask;

endmodule

// File: rtl/bootwin_match.sv
module bootwin_match #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] addr_page,
    input  logic [PAGE_W-1:0] base_page,
    input  logic [PAGE_W-1:0] mask_page,
    output logic              win_en,
    output logic              hit
);
    logic [PAGE_W-1:0] bit_ok;

    // Per page bit: either masked out, or address agrees with base.
    for (genvar i = 0; i < PAGE_W; i++) begin : g_bit
        assign bit_ok[i] = ~mask_page[i] | (addr_page[i] ~^ base_page[i]);
    end

    assign win_en = |mask_page;
    assign hit    = win_en & (&bit_ok);

endmodule

// File: rtl/bootwin_cs.sv
module bootwin_cs
    import bootwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_rd_n,
    input  logic mem_wr_n,
    input  logic io_rd_n,
    input  logic io_wr_n,
    input  logic hit,
    output logic cs_n
);
    typedef struct packed {
        logic cs_n;
    } cs_state_t;

    cs_state_t st_d, st_q;
    bus_kind_e kind;

    always_comb begin
        kind    = classify(mem_rd_n, mem_wr_n, io_rd_n, io_wr_n);
        st_d    = st_q;
        st_d.cs_n = !((kind == BUS_MEM_RD) && hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs_n: 1'b1};
        else        st_q <= st_d;
    end

    assign cs_n = st_q.cs_n;

endmodule

// File: rtl/bootwin_decoder.sv
module bootwin_decoder #(
    parameter int ADDR_W = 20,
    parameter int GRAN_W = 12,
    parameter int REG_AW = 8,
    parameter logic [REG_AW-1:0] BASE_OFS = 8'h30,
    parameter logic [REG_AW-1:0] MASK_OFS = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              mem_rd_n,
    input  logic              mem_wr_n,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    output logic              rom_cs_n
);
    localparam int PAGE_W = ADDR_W - GRAN_W;

    logic [PAGE_W-1:0] base_page;
    logic [PAGE_W-1:0] mask_page;
    logic              win_en;
    logic              hit;
    logic              unused_low;

    // Sub-page bits never take part in the decode.
    assign unused_low = ^{reg_wdata[GRAN_W-1:0], host_addr[GRAN_W-1:0], win_en};

    bootwin_regs #(
        .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .REG_AW(REG_AW),
        .BASE_OFS(BASE_OFS), .MASK_OFS(MASK_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .wr_page   (reg_wdata[ADDR_W-1:GRAN_W]),
        .base_page (base_page),
        .mask_page (mask_page)
    );

    bootwin_match #(.PAGE_W(PAGE_W)) u_match (
        .addr_page (host_addr[ADDR_W-1:GRAN_W]),
        .base_page (base_page),
        .mask_page (mask_page),
        .win_en    (win_en),
        .hit       (hit)
    );

    bootwin_cs u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n),
        .hit      (hit),
        .cs_n     (rom_cs_n)
    );

endmodule

// File: rtl/bootwin_decoder_chk.sv
module bootwin_decoder_chk #(
    parameter int ADDR_W = 20,
    parameter int GRAN_W = 12,
    parameter int REG_AW = 8,
    parameter logic [REG_AW-1:0] MASK_OFS = 8'h34
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [REG_AW-1:0]        reg_addr,
    input logic                     mem_rd_n,
    input logic                     mem_wr_n,
    input logic                     io_rd_n,
    input logic                     io_wr_n,
    input logic                     rom_cs_n,
    input logic [ADDR_W-GRAN_W-1:0] mask_page,
    input logic                     hit
);
    // R2: mask register moves only after a write aimed at its offset
    assert_mask_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(reg_wr) && ($past(reg_addr) == MASK_OFS)) |-> $stable(mask_page));

    // R3: select follows the comparator result of the previous cycle
    assert_cs_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> $past(hit));

    // R4: only a lone memory read strobe may select the ROM
    assert_cs_only_memrd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> $past(!mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

    // R5: released read strobe deselects on the next edge
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd_n) |-> rom_cs_n);

    // R6: empty page mask keeps the window closed
    assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_page == '0) |-> rom_cs_n);

endmodule

bind bootwin_decoder bootwin_decoder_chk #(
    .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .REG_AW(REG_AW), .MASK_OFS(MASK_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .rom_cs_n  (rom_cs_n),
    .mask_page (mask_page),
    .hit       (hit)
);

// File: tb/bootwin_decoder_bench.sv
module bootwin_decoder_bench;

    localparam logic [3:0] RD   = 4'b0111;  // {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
    localparam logic [3:0] IDLE = 4'b1111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int vectors = 0;
    int fails = 0;

    // default-size instance
    logic        b_wr = 1'b0;
    logic [7:0]  b_ofs = '0;
    logic [19:0] b_wdata = '0;
    logic [19:0] b_addr = '0;
    logic [3:0]  b_strb = IDLE;
    logic        b_cs_n;

    // reduced instance: 14-bit address, 256-byte pages, 6 page bits
    logic        s_wr = 1'b0;
    logic [7:0]  s_ofs = '0;
    logic [13:0] s_wdata = '0;
    logic [13:0] s_addr = '0;
    logic [3:0]  s_strb = IDLE;
    logic        s_cs_n;

    bootwin_decoder u_bootwin_decoder (
        .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_addr(b_ofs), .reg_wdata(b_wdata),
        .host_addr(b_addr), .mem_rd_n(b_strb[3]), .mem_wr_n(b_strb[2]),
        .io_rd_n(b_strb[1]), .io_wr_n(b_strb[0]), .rom_cs_n(b_cs_n)
    );

    bootwin_decoder #(.ADDR_W(14), .GRAN_W(8)) u_bootwin_decoder_small (
        .clk(clk), .rst_n(rst_n), .reg_wr(s_wr), .reg_addr(s_ofs), .reg_wdata(s_wdata),
        .host_addr(s_addr), .mem_rd_n(s_strb[3]), .mem_wr_n(s_strb[2]),
        .io_rd_n(s_strb[1]), .io_wr_n(s_strb[0]), .rom_cs_n(s_cs_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rom_cs_n actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic b_write(input logic [7:0] ofs, input logic [19:0] data);
        b_wr = 1'b1; b_ofs = ofs; b_wdata = data; b_strb = IDLE;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    // drive one bus cycle, check the select registered at the next edge
    task automatic b_probe(input logic [19:0] addr, input logic [3:0] strb,
                           input logic sel, input string req);
        b_addr = addr; b_strb = strb;
        @(negedge clk);
        check(req, b_cs_n, !sel);
    endtask

    task automatic s_write(input logic [7:0] ofs, input logic [13:0] data);
        s_wr = 1'b1; s_ofs = ofs; s_wdata = data; s_strb = IDLE;
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: after reset the window is off even for a read at base 0
        b_probe(20'h00000, RD, 1'b0, "R1 reset window off");
        b_probe(20'h00123, RD, 1'b0, "R1 reset window off");

        // R7: documented 16 KB example
        b_write(8'h30, 20'hD0000);
        b_write(8'h34, 20'hFC000);
        b_probe(20'hD0000, RD, 1'b1, "R7 first byte");
        b_probe(20'hD3FFF, RD, 1'b1, "R7 last byte");
        b_probe(20'hD2ABC, RD, 1'b1, "R7 inside");
        b_probe(20'hCFFFF, RD, 1'b0, "R7 below");
        b_probe(20'hD4000, RD, 1'b0, "R7 above");
        b_probe(20'h50000, RD, 1'b0, "R3 top bit differs");

        // R4: strobe qualification
        b_probe(20'hD1000, 4'b1011, 1'b0, "R4 memory write");
        b_probe(20'hD1000, 4'b1101, 1'b0, "R4 io read");
        b_probe(20'hD1000, 4'b1110, 1'b0, "R4 io write");
        b_probe(20'hD1000, 4'b0011, 1'b0, "R4 read plus write");
        b_probe(20'hD1000, IDLE,    1'b0, "R4 idle");

        // R5: hold and release
        b_probe(20'hD1000, RD, 1'b1, "R5 hold 1");
        b_probe(20'hD1000, RD, 1'b1, "R5 hold 2");
        b_probe(20'hD1000, RD, 1'b1, "R5 hold 3");
        b_probe(20'hD1000, IDLE, 1'b0, "R5 release");

        // R2: writes to other offsets leave the window alone
        b_write(8'h31, 20'h00000);
        b_write(8'h38, 20'h00000);
        b_write(8'h00, 20'hFFFFF);
        b_probe(20'hD3FFF, RD, 1'b1, "R2 stray offsets ignored");
        b_probe(20'hD4000, RD, 1'b0, "R2 stray offsets ignored");

        // R8: low mask bits ignored
        b_write(8'h34, 20'hFCFFF);
        b_probe(20'hD3FFF, RD, 1'b1, "R8 low mask bits");
        b_probe(20'hD4000, RD, 1'b0, "R8 low mask bits");
        b_probe(20'hCFFFF, RD, 1'b0, "R8 low mask bits");

        // R2: base change with a 64 KB mask
        b_write(8'h30, 20'h40ABC);
        b_write(8'h34, 20'hF0000);
        b_probe(20'h4FFFF, RD, 1'b1, "R2 new base");
        b_probe(20'h40000, RD, 1'b1, "R2 new base");
        b_probe(20'hD0000, RD, 1'b0, "R2 old base gone");

        // R6: page bits empty, low bits set
        b_write(8'h34, 20'h00FFF);
        b_probe(20'h40000, RD, 1'b0, "R6 disabled");
        b_probe(20'h00000, RD, 1'b0, "R6 disabled");
        b_probe(20'hFFFFF, RD, 1'b0, "R6 disabled");
        b_strb = IDLE;

        // R3 sweep on the reduced instance: every mask, two bases, every page
        for (int m = 0; m < 64; m++) begin
            for (int v = 0; v < 2; v++) begin
                int bp;
                bp = (m * 37 + 5) & 63;
                if (v == 1) bp = (~bp) & 63;
                s_write(8'h30, {6'(bp), 8'h5A});
                s_write(8'h34, {6'(m), 8'hC3});
                s_write(8'h33, 14'h3FFF);
                s_write(8'h00, 14'h0000);
                for (int p = 0; p < 64; p++) begin
                    logic [3:0] strb;
                    logic       sel;
                    strb = (p % 2 == 0) ? RD : 4'((p >> 1) + m);
                    sel  = (strb == RD) && (m != 0) && ((p & m) == (bp & m));
                    s_addr = {6'(p), 8'((p * 53 + m) & 255)};
                    s_strb = strb;
                    @(negedge clk);
                    if (m == 0) check("R6 sweep", s_cs_n, !sel);
                    else        check("R3 sweep", s_cs_n, !sel);
                end
                s_strb = IDLE;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule